// File: doc/BRIEF.md
# Host-Settable Device Timestamp

This block keeps a 64-bit device time that host software can load and read back through two mailbox-style commands. A free-running local time base counts nanoseconds by adding a fixed step every clock. A set command stores the host's 64-bit value together with the time-base reading of that cycle. A later get returns the stored host value plus the nanoseconds that have passed since that set. Until the first set has been accepted, a get returns zero.

Commands arrive on a valid/ready channel: a command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high. Its inputs must stay stable while `cmd_valid` is high and `cmd_ready` is low. Each accepted command produces exactly one response on a valid/ready channel, in the cycle after acceptance. A response that meets a low `rsp_ready` stays on the pins unchanged until it is taken. While it waits, the command channel applies back-pressure (`cmd_ready` low). Response payload bytes are little-endian: byte k sits in bits 8k+7 to 8k.

Top module: `ts_stamp_unit`

## Requirements
- R1: A get accepted before any well-formed set since reset returns payload 0, length 8 and code 0x00.
- R2: After a set carrying H, accepted when the time base read S, a get accepted when it reads T returns H + (T − S). The time base is 0 in the first cycle after reset and advances by NS_PER_CLK every clock.
- R3: A well-formed get (cmd_len 0) answers with rsp_len 8, and the value is little-endian (byte k in bits 8k+7:8k).
- R4: A well-formed set (cmd_len 8) loads the host value and answers with rsp_len 0 and payload 0.
- R5: Every well-formed get or set answers with return code 0x00 (success).
- R6: rsp_effect has bit 3 (immediate policy change) set for a well-formed set and is 0 for every other response.
- R7: The sum and the difference in R2 wrap modulo 2^64.
- R8: A later set replaces both the stored host value and its capture time.
- R9: A response is valid in the cycle after acceptance. It holds stable while rsp_ready is low. cmd_ready equals (not rsp_valid) or rsp_ready.
- R10: A set with cmd_len not 8, or a get with cmd_len not 0, answers with code 0x16, length 0, payload 0 and effect 0. It changes no stored state.
- R11: While reset is asserted, rsp_valid is low, and the time base restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_is_set | input | 1 | 1 = set time, 0 = get time |
| cmd_len | input | 16 | Input payload length in bytes |
| cmd_data | input | 64 | Input payload (host time for a set) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_data | output | 64 | Output payload, little-endian |
| rsp_len | output | 16 | Output payload length in bytes |
| rsp_code | output | 8 | Return code (0x00 success, 0x16 bad length) |
| rsp_effect | output | 8 | Command effect flags (bit 3 = policy change) |

## Verification
Several properties are checked on every cycle:
- a response that is refused stays unchanged;
- every accepted command yields a response on the next cycle;
- a get issued before any set yields zero;
- a set latches the host value and the current time;
- responses with nonzero effect or with a bad-length code carry the expected length and payload.

Only the bench's scenarios can show the rest:
- the elapsed-time arithmetic over real gaps between set and get;
- wrap-around past 2^64;
- replacement by a second set;
- malformed commands leaving the stored time untouched.

The bench runs these scenarios against its cycle-by-cycle model.

// File: rtl/ts_pkg.sv
package ts_pkg;
  localparam int unsigned TS_W = 64;
  localparam int unsigned LEN_W = 16;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] RC_OK      = 8'h00;
  localparam logic [CODE_W-1:0] RC_BAD_LEN = 8'h16;
  localparam int unsigned EFF_POLICY_BIT = 3;
  localparam logic [LEN_W-1:0] SET_IN_BYTES  = 16'd8;
  localparam logic [LEN_W-1:0] GET_IN_BYTES  = 16'd0;
  localparam logic [LEN_W-1:0] GET_OUT_BYTES = 16'd8;

  typedef struct packed {
    logic [TS_W-1:0]   data;
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] code;
    logic [7:0]        effect;
  } ts_rsp_t;
endpackage

// File: rtl/ts_timebase.sv
module ts_timebase #(
  parameter int unsigned W = 64,
  parameter int unsigned STEP = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);
  localparam logic [W-1:0] INC = W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + INC;
  end

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(now) |=> now - $past(now) == INC);
endmodule

// File: rtl/ts_anchor.sv
module ts_anchor #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] now,
  output logic         armed,
  output logic [W-1:0] stamp
);
  logic [W-1:0] host_q;
  logic [W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      host_q <= '0;
      cap_q  <= '0;
    end else if (load) begin
      armed  <= 1'b1;
      host_q <= load_val;
      cap_q  <= now;
    end
  end

  // wraps modulo 2^W (R7)
  always_comb stamp = armed ? (host_q + (now - cap_q)) : '0;

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> armed && host_q == $past(load_val) && cap_q == $past(now));
endmodule

// File: rtl/ts_resp.sv
module ts_resp
  import ts_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fire,
  input  ts_rsp_t next,
  input  logic    rsp_ready,
  output logic    rsp_valid,
  output ts_rsp_t rsp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp       <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp       <= next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp));
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit
  import ts_pkg::*;
#(
  parameter int unsigned NS_PER_CLK = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_is_set,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [TS_W-1:0]   cmd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [TS_W-1:0]   rsp_data,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [CODE_W-1:0] rsp_code,
  output logic [7:0]        rsp_effect
);
  logic [TS_W-1:0] now;
  logic [TS_W-1:0] stamp;
  logic            armed;
  logic            fire;
  logic            len_ok;
  logic            do_load;
  ts_rsp_t         nxt;
  ts_rsp_t         cur;

  ts_timebase #(.W(TS_W), .STEP(NS_PER_CLK)) u_tb (
    .clk(clk), .rst_n(rst_n), .now(now));

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign len_ok    = cmd_is_set ? (cmd_len == SET_IN_BYTES) : (cmd_len == GET_IN_BYTES);
  assign do_load   = fire && cmd_is_set && len_ok;

  ts_anchor #(.W(TS_W)) u_anchor (
    .clk(clk), .rst_n(rst_n), .load(do_load), .load_val(cmd_data),
    .now(now), .armed(armed), .stamp(stamp));

  always_comb begin
    nxt = '0;
    if (!len_ok) begin
      nxt.code = RC_BAD_LEN;
    end else if (cmd_is_set) begin
      nxt.code = RC_OK;
      nxt.effect[EFF_POLICY_BIT] = 1'b1;
    end else begin
      nxt.code = RC_OK;
      nxt.len  = GET_OUT_BYTES;
      nxt.data = stamp;
    end
  end

  ts_resp u_resp (
    .clk(clk), .rst_n(rst_n), .fire(fire), .next(nxt),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp(cur));

  assign rsp_data   = cur.data;
  assign rsp_len    = cur.len;
  assign rsp_code   = cur.code;
  assign rsp_effect = cur.effect;

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  assert_unset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !cmd_is_set && cmd_len == GET_IN_BYTES && !armed |=> rsp_data == '0);
  assert_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_effect != '0 |-> rsp_len == '0 && rsp_code == RC_OK);
  assert_badlen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == RC_BAD_LEN |-> rsp_len == '0 && rsp_data == '0 && rsp_effect == '0);
  assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_len == '0 || rsp_len == GET_OUT_BYTES);
endmodule

// File: tb/ts_stamp_unit_test.sv
module ts_stamp_unit_test;
  localparam int unsigned STEP = 20;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_is_set, rsp_valid, rsp_ready;
  logic [15:0] cmd_len, rsp_len;
  logic [63:0] cmd_data, rsp_data;
  logic [7:0] rsp_code, rsp_effect;

  ts_stamp_unit #(.NS_PER_CLK(STEP)) uut (.*);

  int n_chk = 0, n_fail = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] m_now, m_host, m_cap, e_data;
  logic m_armed, e_valid, acc;
  logic [15:0] e_len;
  logic [7:0] e_code, e_eff;
  string e_tag;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_now = 0; m_armed = 0; m_host = 0; m_cap = 0; e_valid = 0;
    end else begin
      acc = cmd_valid && (!e_valid || rsp_ready);
      if (e_valid && rsp_ready) e_valid = 0;
      if (acc) begin
        e_valid = 1; e_data = 0; e_len = 0; e_eff = 0; e_code = 8'h00;
        if (cmd_is_set ? cmd_len != 8 : cmd_len != 0) begin
          e_code = 8'h16; e_tag = "R10 bad length";
        end else if (cmd_is_set) begin
          e_eff = 8'h08; m_armed = 1; m_host = cmd_data; m_cap = m_now;
          e_tag = "R4/R5/R6 set";
        end else begin
          e_len = 8;
          e_data = m_armed ? m_host + (m_now - m_cap) : 64'd0;
          e_tag = m_armed ? "R2/R3/R5 get" : "R1 get before set";
        end
      end
      m_now = m_now + STEP;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R9 rsp_valid", rsp_valid, e_valid);
      chk("R9 cmd_ready", cmd_ready, !e_valid || rsp_ready);
      if (e_valid) begin
        chk({e_tag, " data"}, rsp_data, e_data);
        chk({e_tag, " len"}, rsp_len, e_len);
        chk({e_tag, " code"}, rsp_code, e_code);
        chk({e_tag, " effect"}, rsp_effect, e_eff);
      end
    end
  end

  task automatic issue(logic is_set, logic [15:0] len, logic [63:0] d);
    cmd_valid = 1; cmd_is_set = is_set; cmd_len = len; cmd_data = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    cmd_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_is_set = 0; cmd_len = 0; cmd_data = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    chk("R11 reset rsp_valid", rsp_valid, 0);
    chk("R11 reset cmd_ready", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    // R1: get before any set
    issue(0, 0, 64'hdead); idle(2);
    // R10: malformed set must not arm
    issue(1, 4, 64'h1234); issue(0, 0, 0); idle(1);
    chk("R10 malformed set left unarmed", rsp_data, 0);
    idle(1);
    issue(0, 3, 0); idle(2);
    // R2/R3/R4
    issue(1, 8, 64'h0102_0304_0506_0708); idle(5);
    issue(0, 0, 0); idle(1);
    chk("R3 byte0 little-endian", rsp_data[7:0], 8'h08 + 8'd120);
    idle(3);
    // R7: wrap, set then get back-to-back -> elapsed one step
    issue(1, 8, 64'hFFFF_FFFF_FFFF_FFF0); issue(0, 0, 0); idle(0);
    chk("R7 wrap", rsp_data, 64'd4);
    idle(2);
    // R8: second set replaces both
    issue(1, 8, 64'd1000); idle(7);
    issue(1, 8, 64'd5000); issue(0, 0, 0); idle(0);
    chk("R8 replaced value", rsp_data, 64'd5020);
    idle(2);
    // R9: back-pressure
    rsp_ready = 0;
    fork
      begin issue(0, 0, 0); issue(1, 8, 64'd77); issue(0, 0, 0); end
      begin repeat (4) @(negedge clk); rsp_ready = 1; end
    join
    idle(3);
    chk("R9 idle after drain", rsp_valid, 0);
    issue(0, 8, 0); idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule